// File: doc/BRIEF.md
# Fixed-Point Programmable-Increment Time Counter

This block keeps a 64-bit scaled time value that advances on every cycle of the local oscillator. On each cycle it adds a programmable increment, and that increment is a fixed-point fraction of a nanosecond. Because the increment is the oscillator period multiplied by a power of two, whole nanoseconds are recovered by shifting the count right. A link-speed code selects a base increment and shift pair. The block derives that pair itself and loads it when software asks for a resynchronisation and either the decoded rate has changed or the increment field is zero. In both cases the count restarts from zero.

Software can write the increment directly or ask for a frequency trim. A trim scales the base increment up or down by a signed parts-per-billion amount. Software can also zero the count. Reading the count uses two 32-bit words. Strobing the low-word read captures the high word in the same cycle, so a carry between the two reads cannot tear the value. A parameter selects a narrow variant. That variant keeps a 24-bit increment field, divides the base increment by 128 and reduces the shift by 7.

Top module: `tc_clock`

## Requirements
- R1: After synchronous reset the count, the captured high word, the increment register and the reported shift are all zero.
- R2: On every clock the count grows by the increment field: bits 30:0 of the increment register in the wide variant and bits 23:0 in the narrow variant. A zero field leaves the count unchanged.
- R3: The speed code selects the rate. Code 2'b00 gives base 0x66666666 with shift 28 (about 6.4 ns per cycle). Code 2'b01 gives 0x40000000 with shift 24 (64 ns). Code 2'b10 gives 0x50000000 with shift 21 (640 ns). Code 2'b11 (no link) uses the 2'b00 rate. In the narrow variant the base is shifted right by 7, the shift is reduced by 7, and the register value also has bit 24 set.
- R4: A resync strobe reloads the block when the decoded rate differs from the rate held or the increment field is zero. A reload takes effect one cycle later: the increment register becomes the register value for the rate, the count becomes zero and the rate is held. In all other cases the strobe has no effect.
- R5: A trim strobe sets the increment to base ± floor(base × m / 10^9). Here base is the held rate's base increment and m is the magnitude of the signed 32-bit ppb input, clamped to 250,000,000. The sign of the ppb input picks plus or minus. In the narrow variant bit 24 is also set.
- R6: A write strobe loads the 32-bit write data into the increment register one cycle later.
- R7: The clear strobe zeroes the count one cycle later and leaves the increment unchanged, so counting resumes from zero.
- R8: The low-word output shows the live count bits 31:0. A low-word read strobe captures count bits 63:32 from that same cycle into the high-word output, which then holds until the next low-word read.
- R9: The nanosecond output is the count shifted right by the held shift. After N cycles at a rate it equals N times the period, within one nanosecond.
- R10: A reload takes priority over a write, and a write takes priority over a trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_code | input | 2 | Link speed code |
| resync | input | 1 | Rate check and reload strobe |
| inc_wr | input | 1 | Increment write strobe |
| inc_wdata | input | 32 | Increment write data |
| ppb_wr | input | 1 | Frequency trim strobe |
| ppb_value | input | 32 | Signed trim in parts per billion |
| clr_time | input | 1 | Zero the count |
| rd_lo | input | 1 | Low-word read strobe; captures the high word |
| inc_rdata | output | 32 | Increment register |
| time_lo | output | 32 | Live count bits 31:0 |
| time_hi_snap | output | 32 | High word captured at the last low-word read |
| ns_out | output | 64 | Count shifted right by the held shift |
| shift_out | output | 6 | Held shift amount |

## Verification
Every strobe (resync, write, trim, clear, low-word read) is sampled on one clock edge and shows its result on the outputs right after that same edge. The count therefore has added exactly one increment for each edge since the last reload or clear. The driver drives inputs just after a rising edge and counts edges from that point to predict the count, then queues its expected values. The monitor compares the queued values at the next falling edge, one edge after each strobe, or N edges after a reload when checking accumulation. The nanosecond checks run for a fixed number of cycles at each rate and allow one unit of truncation.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int unsigned PPB_LIMIT  = 250_000_000;
    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
    localparam int unsigned NARROW_DROP = 7;
    localparam int unsigned NARROW_MARK = 24;

    typedef enum logic [1:0] {
        RATE_FAST = 2'd0,
        RATE_MID  = 2'd1,
        RATE_SLOW = 2'd2,
        RATE_NONE = 2'd3
    } rate_e;

    typedef struct packed {
        logic [31:0] base;
        logic [5:0]  shift;
    } rate_cfg_t;

    function automatic rate_e decode_speed(input logic [1:0] code);
        case (code)
            2'b01:   return RATE_MID;
            2'b10:   return RATE_SLOW;
            default: return RATE_FAST;
        endcase
    endfunction

    function automatic rate_cfg_t wide_cfg(input rate_e r);
        rate_cfg_t c;
        case (r)
            RATE_MID:  begin c.base = 32'h4000_0000; c.shift = 6'd24; end
            RATE_SLOW: begin c.base = 32'h5000_0000; c.shift = 6'd21; end
            default:   begin c.base = 32'h6666_6666; c.shift = 6'd28; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tc_rate_sel.sv
module tc_rate_sel
    import tc_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  rate_e       rate,
    output rate_cfg_t   cfg,
    output logic [31:0] reg_val
);
    rate_cfg_t wide;

    always_comb wide = wide_cfg(rate);

    generate
        if (NARROW) begin : g_narrow
            always_comb begin
                cfg.base  = wide.base >> NARROW_DROP;
                cfg.shift = wide.shift - 6'(NARROW_DROP);
                reg_val   = cfg.base | (32'd1 << NARROW_MARK);
            end
        end else begin : g_wide
            always_comb begin
                cfg     = wide;
                reg_val = wide.base;
            end
        end
    endgenerate
endmodule

// File: rtl/tc_trim.sv
module tc_trim
    import tc_pkg::*;
(
    input  logic [31:0] base,
    input  logic [31:0] ppb,
    output logic [31:0] trimmed
);
    logic        neg;
    logic [32:0] mag;
    logic [32:0] mag_c;
    logic [63:0] prod;
    logic [63:0] diff;

    always_comb begin
        neg   = ppb[31];
        mag   = neg ? (33'd0 - {ppb[31], ppb}) : {1'b0, ppb};
        mag_c = (mag > 33'(PPB_LIMIT)) ? 33'(PPB_LIMIT) : mag;
        prod  = {32'd0, base} * {31'd0, mag_c};
        diff  = prod / NS_PER_S;
        trimmed = neg ? (base - diff[31:0]) : (base + diff[31:0]);
    end
endmodule

// File: rtl/tc_time_reg.sv
module tc_time_reg #(
    parameter int TIME_W  = 64,
    parameter int FIELD_W = 31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FIELD_W-1:0]  inc_field,
    input  logic                zero_i,
    input  logic                rd_lo_i,
    output logic [TIME_W-1:0]   time_q,
    output logic [TIME_W/2-1:0] hi_snap_q
);
    localparam int HALF_W = TIME_W / 2;
    localparam int PAD_W  = TIME_W - FIELD_W;

    logic [TIME_W-1:0] step;

    always_comb step = {{PAD_W{1'b0}}, inc_field};

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
        end else if (zero_i) begin
            time_q <= '0;
        end else begin
            time_q <= time_q + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_snap_q <= '0;
        end else if (rd_lo_i) begin
            hi_snap_q <= time_q[TIME_W-1:HALF_W];
        end
    end

    // R2: a zero increment freezes the count
    a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
        (inc_field == '0 && !zero_i) |=> $stable(time_q));

    // R7: clearing yields zero
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        zero_i |=> (time_q == '0));

    // R8: captured high word holds between reads
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_lo_i |=> $stable(hi_snap_q));
endmodule

// File: rtl/tc_clock.sv
module tc_clock
    import tc_pkg::*;
#(
    parameter bit NARROW = 1'b0,
    parameter int TIME_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         speed_code,
    input  logic               resync,
    input  logic               inc_wr,
    input  logic [31:0]        inc_wdata,
    input  logic               ppb_wr,
    input  logic [31:0]        ppb_value,
    input  logic               clr_time,
    input  logic               rd_lo,
    output logic [31:0]        inc_rdata,
    output logic [31:0]        time_lo,
    output logic [31:0]        time_hi_snap,
    output logic [TIME_W-1:0]  ns_out,
    output logic [5:0]         shift_out
);
    localparam int FIELD_W = NARROW ? 24 : 31;

    rate_e        rate_now;
    rate_e        rate_q;
    rate_cfg_t    cfg_now;
    rate_cfg_t    cfg_q;
    logic [31:0]  reg_now;
    logic [31:0]  inc_q;
    logic [31:0]  trimmed;
    logic [31:0]  trim_reg;
    logic [FIELD_W-1:0] inc_field;
    logic [31:0]  inc_field_x;
    logic         need_reload;
    logic [TIME_W-1:0] time_q;

    always_comb rate_now = decode_speed(speed_code);

    tc_rate_sel #(.NARROW(NARROW)) u_sel (
        .rate    (rate_now),
        .cfg     (cfg_now),
        .reg_val (reg_now)
    );

    tc_trim u_trim (
        .base    (cfg_q.base),
        .ppb     (ppb_value),
        .trimmed (trimmed)
    );

    generate
        if (NARROW) begin : g_nf
            always_comb trim_reg = {8'd0, trimmed[23:0]} | (32'd1 << NARROW_MARK);
        end else begin : g_wf
            always_comb trim_reg = trimmed;
        end
    endgenerate

    always_comb begin
        inc_field   = inc_q[FIELD_W-1:0];
        inc_field_x = 32'(inc_field);
        need_reload = resync && ((rate_now != rate_q) || (inc_field == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_NONE;
            cfg_q  <= '0;
            inc_q  <= '0;
        end else if (need_reload) begin
            rate_q <= rate_now;
            cfg_q  <= cfg_now;
            inc_q  <= reg_now;
        end else if (inc_wr) begin
            inc_q  <= inc_wdata;
        end else if (ppb_wr) begin
            inc_q  <= trim_reg;
        end
    end

    tc_time_reg #(.TIME_W(TIME_W), .FIELD_W(FIELD_W)) u_time (
        .clk       (clk),
        .rst       (rst),
        .inc_field (inc_field),
        .zero_i    (need_reload || clr_time),
        .rd_lo_i   (rd_lo),
        .time_q    (time_q),
        .hi_snap_q (time_hi_snap)
    );

    always_comb begin
        inc_rdata = inc_q;
        time_lo   = time_q[31:0];
        ns_out    = time_q >> cfg_q.shift;
        shift_out = cfg_q.shift;
    end

    // R4: reload loads the rate value and restarts the count
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        need_reload |=> (inc_q == $past(reg_now)) && (time_lo == 32'd0));

    // R6, R10: a write lands unless a reload wins
    a_r6_write: assert property (@(posedge clk) disable iff (rst)
        (inc_wr && !need_reload) |=> (inc_q == $past(inc_wdata)));

    // R5: trimmed field stays within a quarter of the base
    a_r5_trim_bound: assert property (@(posedge clk) disable iff (rst)
        (ppb_wr && !inc_wr && !need_reload) |=>
            ((inc_field_x <= $past(cfg_q.base) + ($past(cfg_q.base) >> 2)) &&
             (inc_field_x >= $past(cfg_q.base) - ($past(cfg_q.base) >> 2))));
endmodule

// File: tb/tc_clock_test.sv
module tc_clock_test;

    typedef struct {
        string           tag;
        int              sel;
        longint unsigned exp;
        longint unsigned tol;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  speed_code = 0;
    logic        resync = 0, inc_wr = 0, ppb_wr = 0, clr_time = 0, rd_lo = 0;
    logic [31:0] inc_wdata = 0, ppb_value = 0;

    logic [31:0] inc_w, lo_w, hi_w, inc_n, lo_n, hi_n;
    logic [63:0] ns_w, ns_n;
    logic [5:0]  sh_w, sh_n;

    always #10 clk = ~clk;

    tc_clock #(.NARROW(1'b0)) uut (
        .clk(clk), .rst(rst), .speed_code(speed_code), .resync(resync),
        .inc_wr(inc_wr), .inc_wdata(inc_wdata), .ppb_wr(ppb_wr),
        .ppb_value(ppb_value), .clr_time(clr_time), .rd_lo(rd_lo),
        .inc_rdata(inc_w), .time_lo(lo_w), .time_hi_snap(hi_w),
        .ns_out(ns_w), .shift_out(sh_w));

    tc_clock #(.NARROW(1'b1)) uut_n (
        .clk(clk), .rst(rst), .speed_code(speed_code), .resync(resync),
        .inc_wr(inc_wr), .inc_wdata(inc_wdata), .ppb_wr(ppb_wr),
        .ppb_value(ppb_value), .clr_time(clr_time), .rd_lo(rd_lo),
        .inc_rdata(inc_n), .time_lo(lo_n), .time_hi_snap(hi_n),
        .ns_out(ns_n), .shift_out(sh_n));

    // expected-value model from the requirements
    function automatic longint unsigned base_of(int r, bit n);
        longint unsigned b;
        b = (r == 1) ? 64'h4000_0000 : (r == 2) ? 64'h5000_0000 : 64'h6666_6666;
        return n ? (b >> 7) : b;
    endfunction

    function automatic longint unsigned shift_of(int r, bit n);
        longint unsigned s;
        s = (r == 1) ? 24 : (r == 2) ? 21 : 28;
        return n ? s - 7 : s;
    endfunction

    function automatic longint unsigned reg_of(int r, bit n);
        return n ? (base_of(r, n) | (64'd1 << 24)) : base_of(r, n);
    endfunction

    function automatic longint unsigned trim_of(int r, bit n, int ppb);
        longint signed p;
        longint unsigned mag, b, d, res;
        p   = ppb;
        mag = (p < 0) ? longint'(-p) : longint'(p);
        if (mag > 250_000_000) mag = 250_000_000;
        b   = base_of(r, n);
        d   = (b * mag) / 1_000_000_000;
        res = (p < 0) ? b - d : b + d;
        return n ? (res | (64'd1 << 24)) : res;
    endfunction

    function automatic longint unsigned pick(int sel);
        case (sel)
            0: return 64'(lo_w);
            1: return 64'(hi_w);
            2: return 64'(inc_w);
            3: return ns_w;
            4: return 64'(sh_w);
            10: return 64'(lo_n);
            11: return 64'(hi_n);
            12: return 64'(inc_n);
            13: return ns_n;
            default: return 64'(sh_n);
        endcase
    endfunction

    task automatic expect_item(string tag, int sel, longint unsigned exp, longint unsigned tol);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp; it.tol = tol;
        sb.push_back(it);
    endtask

    // checks both variants: w for the wide one, n for the narrow one
    task automatic expect_pair(string tag, int sel, longint unsigned ew, longint unsigned en,
                               longint unsigned tol);
        expect_item({tag, " wide"}, sel, ew, tol);
        expect_item({tag, " narrow"}, sel + 10, en, tol);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: compares queued items away from the rising edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            longint unsigned act, dlt;
            it  = sb.pop_front();
            act = pick(it.sel);
            dlt = (act > it.exp) ? act - it.exp : it.exp - act;
            checks++;
            if (dlt > it.tol) begin
                fails++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
        end
    end

    function automatic longint unsigned lo32(longint unsigned v);
        return v & 64'hFFFF_FFFF;
    endfunction

    initial begin
        longint unsigned tw, tn;
        tick(3);
        rst = 0;
        // R1 reset state
        expect_pair("R1 count", 0, 0, 0, 0);
        expect_pair("R1 hi", 1, 0, 0, 0);
        expect_pair("R1 inc", 2, 0, 0, 0);
        expect_pair("R1 shift", 4, 0, 0, 0);
        tick(5);
        expect_pair("R2 zero increment freezes", 0, 0, 0, 0);

        // fastest rate via resync
        speed_code = 2'b00; resync = 1; tick(1); resync = 0;
        expect_pair("R4 reload inc fast", 2, reg_of(0,0), reg_of(0,1), 0);
        expect_pair("R3 shift fast", 4, shift_of(0,0), shift_of(0,1), 0);
        expect_pair("R4 reload count", 0, 0, 0, 0);
        tick(1000);
        expect_pair("R9 ns fast", 3, 6400, 6400, 1);
        expect_pair("R2 accumulate fast", 0, lo32(1000*base_of(0,0)), lo32(1000*base_of(0,1)), 0);

        // R8 low read captures high word of the same cycle
        tw = 1000*base_of(0,0); tn = 1000*base_of(0,1);
        rd_lo = 1; tick(1); rd_lo = 0;
        expect_pair("R8 snap", 1, tw >> 32, tn >> 32, 0);
        tick(300);
        expect_pair("R8 snap holds", 1, tw >> 32, tn >> 32, 0);
        expect_pair("R9 ns exact fast", 3, (1301*base_of(0,0)) >> 28,
                    (1301*base_of(0,1)) >> 21, 0);

        // middle rate
        speed_code = 2'b01; resync = 1; tick(1); resync = 0;
        expect_pair("R3 inc mid", 2, reg_of(1,0), reg_of(1,1), 0);
        expect_pair("R3 shift mid", 4, shift_of(1,0), shift_of(1,1), 0);
        expect_pair("R4 count restart mid", 0, 0, 0, 0);
        tick(500);
        expect_pair("R9 ns mid", 3, 32000, 32000, 1);

        // slowest rate
        speed_code = 2'b10; resync = 1; tick(1); resync = 0;
        expect_pair("R3 inc slow", 2, reg_of(2,0), reg_of(2,1), 0);
        expect_pair("R3 shift slow", 4, shift_of(2,0), shift_of(2,1), 0);
        tick(200);
        expect_pair("R9 ns slow", 3, 128000, 128000, 1);

        // no-link code keeps the fast rate without a reload
        speed_code = 2'b00; resync = 1; tick(1); resync = 0;
        tick(9);
        speed_code = 2'b11; resync = 1; tick(1); resync = 0;
        expect_pair("R3 R4 no-link no reload", 0, lo32(10*base_of(0,0)), lo32(10*base_of(0,1)), 0);
        expect_pair("R4 inc kept", 2, reg_of(0,0), reg_of(0,1), 0);

        // R6 write zero then freeze, R4 reload on zero field
        inc_wdata = 0; inc_wr = 1; tick(1); inc_wr = 0;
        expect_pair("R6 write zero", 2, 0, 0, 0);
        tick(4);
        expect_pair("R2 frozen after write", 0, lo32(11*base_of(0,0)), lo32(11*base_of(0,1)), 0);
        resync = 1; tick(1); resync = 0;
        expect_pair("R4 reload on zero inc", 2, reg_of(0,0), reg_of(0,1), 0);
        expect_pair("R4 count cleared", 0, 0, 0, 0);

        // R5 trim
        ppb_value = 100_000_000; ppb_wr = 1; tick(1); ppb_wr = 0;
        expect_pair("R5 trim +100e6", 2, trim_of(0,0,100_000_000), trim_of(0,1,100_000_000), 0);
        ppb_value = -250_000_000; ppb_wr = 1; tick(1); ppb_wr = 0;
        expect_pair("R5 trim -250e6", 2, trim_of(0,0,-250_000_000), trim_of(0,1,-250_000_000), 0);
        ppb_value = 300_000_000; ppb_wr = 1; tick(1); ppb_wr = 0;
        expect_pair("R5 trim clamp", 2, 64'h7FFF_FFFF, 64'h01FF_FFFF, 0);
        ppb_value = 32'h8000_0000; ppb_wr = 1; tick(1); ppb_wr = 0;
        expect_pair("R5 trim most negative", 2, trim_of(0,0,-250_000_000), trim_of(0,1,-250_000_000), 0);

        // R7 clear keeps increment
        clr_time = 1; tick(1); clr_time = 0;
        expect_pair("R7 cleared", 0, 0, 0, 0);
        expect_pair("R7 inc kept", 2, trim_of(0,0,-250_000_000), trim_of(0,1,-250_000_000), 0);
        tick(3);
        expect_pair("R7 resumes", 0, lo32(3*(trim_of(0,0,-250_000_000) & 64'h7FFF_FFFF)),
                    lo32(3*(trim_of(0,1,-250_000_000) & 64'hFF_FFFF)), 0);

        // R10 priorities
        speed_code = 2'b01; resync = 1; inc_wr = 1; inc_wdata = 32'h0001_2345; tick(1);
        resync = 0; inc_wr = 0;
        expect_pair("R10 reload beats write", 2, reg_of(1,0), reg_of(1,1), 0);
        inc_wr = 1; ppb_wr = 1; inc_wdata = 32'h00AB_CDEF; ppb_value = 5; tick(1);
        inc_wr = 0; ppb_wr = 0;
        expect_pair("R10 R6 write beats trim", 2, 64'h00AB_CDEF, 64'h00AB_CDEF, 0);
        ppb_value = -1; ppb_wr = 1; tick(1); ppb_wr = 0;
        expect_pair("R5 trim from base mid", 2, trim_of(1,0,-1), trim_of(1,1,-1), 0);

        tick(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule